// File: doc/BRIEF.md
# Auto-Reload Timer with Split Mode

This block is a general-purpose 16-bit up-counter. When it rolls over it reloads itself from a 16-bit reload value, so it produces evenly spaced overflow events. Those events set sticky overflow flags and fire a one-cycle pulse. Other logic uses them as periodic interrupt requests or as triggers for neighbouring peripherals.

The timer has two shapes. In the 16-bit shape the whole register counts as one number. In split mode it becomes two independent 8-bit auto-reload timers. Each half then has its own reload byte, its own run enable and its own flag.

The count rate comes from one of three sources: every system clock, every twelfth system clock, or every eighth rising edge of an external oscillator. The external oscillator is synchronised into the system clock domain before it is used. Software may write either byte of the counter at any time, and may clear each flag on its own.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the counter reads 0x0000. Both flags and the pulse output are low.
- R2: In 16-bit mode (split_en=0) the counter advances by one per count tick while run_lo=1, and holds while run_lo=0. run_hi has no effect in this mode.
- R3: In 16-bit mode a tick at 0xFFFF loads the full reload_val and sets ovf_hi. ovf_lo is left unchanged.
- R4: In split mode the low byte (bits 7:0) counts while run_lo=1. A tick at 0xFF loads reload_val[7:0] and sets ovf_lo. No carry passes into the high byte.
- R5: In split mode the high byte (bits 15:8) counts while run_hi=1. A tick at 0xFF loads reload_val[15:8] and sets ovf_hi.
- R6: ovf_pulse is high for exactly one cycle: the cycle in which the reloaded count first appears after any overflow.
- R7: cnt_wr_lo loads cnt_wdata[7:0] into bits 7:0, and cnt_wr_hi loads cnt_wdata[15:8] into bits 15:8. Each takes effect at the next edge and overrides counting and reload. In 16-bit mode a write to either byte stops the whole counter from stepping in that cycle. In split mode only the written byte is held.
- R8: Each flag stays set until its clear input (flag_clr_lo, flag_clr_hi) is high. A new overflow in the same cycle as a clear leaves the flag set.
- R9: clk_sel picks the tick source. 0 gives a tick every cycle. 1 gives a tick every 12th cycle from a free-running prescaler. 2 gives a tick on every 8th synchronised rising edge of ext_osc. 3 gives no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Tick source: 0 system, 1 divide-by-12, 2 external divide-by-8, 3 off |
| ext_osc | input | 1 | External oscillator, asynchronous |
| split_en | input | 1 | 1 = two 8-bit timers, 0 = one 16-bit timer |
| run_lo | input | 1 | Run enable: whole timer in 16-bit mode, low byte in split mode |
| run_hi | input | 1 | Run enable of the high byte in split mode |
| reload_val | input | 16 | Reload value; in split mode bits 15:8 and 7:0 serve the two halves |
| cnt_wr_lo | input | 1 | Write cnt_wdata[7:0] into counter bits 7:0 |
| cnt_wr_hi | input | 1 | Write cnt_wdata[15:8] into counter bits 15:8 |
| cnt_wdata | input | 16 | Counter write data |
| flag_clr_lo | input | 1 | Clear ovf_lo |
| flag_clr_hi | input | 1 | Clear ovf_hi |
| count | output | 16 | Current counter value |
| ovf_lo | output | 1 | Sticky low-byte overflow flag (split mode) |
| ovf_hi | output | 1 | Sticky high or 16-bit overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow event |

## Verification
The bench drives the counter through 0xFFFF with an unusual reload value. A design that reloaded to zero, or that let the high byte carry in split mode, shows a wrong count on the very next cycle. A write is issued while the counter is counting; a design that let the increment win would read one past the written byte. A flag is cleared in the same cycle a fresh overflow arrives; a design that let the clear win would lose an event. The two slow sources are timed over whole periods, so an off-by-one divider shows up as a drifted count.

// File: rtl/rtmr_pkg.sv
// Package: shared types for the reload timer.
// Assumes nothing beyond IEEE 1800-2017.
package rtmr_pkg;
    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_DIV12 = 2'd1,
        SRC_EXT8  = 2'd2,
        SRC_OFF   = 2'd3
    } clk_src_e;
endpackage

// File: rtl/rtmr_tick_gen.sv
// Module: rtmr_tick_gen
// Makes a single-cycle count enable from the selected source: every cycle,
// a free-running divide-by-SYS_DIV prescaler, or every EXT_DIV-th rising
// edge of an asynchronous oscillator after a SYNC_STAGES flop synchroniser.
// Assumes SYS_DIV >= 2, EXT_DIV >= 2 and SYNC_STAGES >= 2. Runs on one clock.
module rtmr_tick_gen
    import rtmr_pkg::*;
#(
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       ext_osc,
    output logic       tick
);
    localparam int SW = $clog2(SYS_DIV);
    localparam int EW = $clog2(EXT_DIV);

    logic [SW-1:0]          sys_cnt_q;
    logic [EW-1:0]          ext_cnt_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_rise;
    logic                   div_tick;
    logic                   ext_tick;

    // Purpose: free-running system-clock prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sys_cnt_q <= '0;
        else if (sys_cnt_q == SW'(SYS_DIV - 1))
            sys_cnt_q <= '0;
        else
            sys_cnt_q <= sys_cnt_q + 1'b1;
    end

    assign div_tick = (sys_cnt_q == SW'(SYS_DIV - 1));

    // Purpose: bring the external oscillator into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_osc};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // Purpose: count synchronised rising edges of the oscillator.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_cnt_q <= '0;
        else if (ext_rise)
            ext_cnt_q <= (ext_cnt_q == EW'(EXT_DIV - 1)) ? '0 : ext_cnt_q + 1'b1;
    end

    assign ext_tick = ext_rise && (ext_cnt_q == EW'(EXT_DIV - 1));

    // Purpose: pick the tick of the selected source.
    always_comb begin
        case (clk_src_e'(clk_sel))
            SRC_SYS:   tick = 1'b1;
            SRC_DIV12: tick = div_tick;
            SRC_EXT8:  tick = ext_tick;
            default:   tick = 1'b0;
        endcase
    end

    // R9: the prescaler tick never lasts two cycles.
    assert_div_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> !div_tick);
    // R9: an external tick happens only on a synchronised rising edge.
    assert_ext_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |-> (sync_q[SYNC_STAGES-1] && !prev_q));
    // R9: the off source never ticks.
    assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'd3) |-> !tick);
endmodule

// File: rtl/rtmr_count_core.sv
// Module: rtmr_count_core
// Holds the counter, the two sticky flags and the overflow pulse. It steps
// in 16-bit or split mode on each tick. Counter writes win over stepping.
// Assumes WIDTH is even; the two halves are WIDTH/2 bits each.
module rtmr_count_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             split_en,
    input  logic             run_lo,
    input  logic             run_hi,
    input  logic [WIDTH-1:0] reload_val,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [WIDTH-1:0] wdata,
    input  logic             clr_lo,
    input  logic             clr_hi,
    output logic [WIDTH-1:0] count,
    output logic             ovf_lo,
    output logic             ovf_hi,
    output logic             ovf_pulse
);
    localparam int HALF = WIDTH / 2;

    logic [1:0][HALF-1:0] cnt_q;
    logic [1:0][HALF-1:0] split_nxt;
    logic [1:0]           split_ev;
    logic [1:0]           run_v;
    logic [1:0]           wr_v;
    logic [1:0][HALF-1:0] rl_v;
    logic [1:0][HALF-1:0] wd_v;
    logic [WIDTH-1:0]     full_nxt;
    logic                 full_ev;
    logic [WIDTH-1:0]     cnt_d;
    logic [1:0]           ev;
    logic [1:0]           flag_q;
    logic                 pulse_q;

    assign run_v = {run_hi, run_lo};
    assign wr_v  = {wr_hi, wr_lo};
    assign rl_v  = reload_val;
    assign wd_v  = wdata;

    // Split mode: each half is its own auto-reload timer.
    for (genvar g = 0; g < 2; g++) begin : g_half
        // Purpose: next value and overflow event of one 8-bit half.
        always_comb begin
            split_nxt[g] = cnt_q[g];
            split_ev[g]  = 1'b0;
            if (wr_v[g])
                split_nxt[g] = wd_v[g];
            else if (tick && run_v[g]) begin
                if (&cnt_q[g]) begin
                    split_nxt[g] = rl_v[g];
                    split_ev[g]  = 1'b1;
                end else
                    split_nxt[g] = cnt_q[g] + 1'b1;
            end
        end
    end

    // Purpose: next value and overflow event of the full-width timer.
    always_comb begin
        full_nxt = cnt_q;
        full_ev  = 1'b0;
        if (|wr_v) begin
            full_nxt[HALF-1:0]     = wr_lo ? wd_v[0] : cnt_q[0];
            full_nxt[WIDTH-1:HALF] = wr_hi ? wd_v[1] : cnt_q[1];
        end else if (tick && run_lo) begin
            if (&cnt_q) begin
                full_nxt = reload_val;
                full_ev  = 1'b1;
            end else
                full_nxt = cnt_q + 1'b1;
        end
    end

    // Purpose: choose the mode's result.
    always_comb begin
        if (split_en) begin
            cnt_d = split_nxt;
            ev    = split_ev;
        end else begin
            cnt_d = full_nxt;
            ev    = {full_ev, 1'b0};
        end
    end

    // Purpose: register counter, sticky flags and event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            flag_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            flag_q  <= (flag_q & ~{clr_hi, clr_lo}) | ev;
            pulse_q <= |ev;
        end
    end

    assign count     = cnt_q;
    assign ovf_lo    = flag_q[0];
    assign ovf_hi    = flag_q[1];
    assign ovf_pulse = pulse_q;

    // R3: a full-width rollover loads the reload value and sets the high flag.
    assert_reload16_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_en && tick && run_lo && !wr_lo && !wr_hi && (&count))
        |=> (count == $past(reload_val)) && ovf_hi);
    // R4: a low-half rollover in split mode reloads the low byte and sets its flag.
    assert_split_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_en && tick && run_lo && !wr_lo && (&count[HALF-1:0]))
        |=> (count[HALF-1:0] == $past(reload_val[HALF-1:0])) && ovf_lo);
    // R4: the high half does not move in split mode unless it runs or is written.
    assert_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_en && !wr_hi && !(tick && run_hi)) |=> $stable(count[WIDTH-1:HALF]));
    // R7: a low-byte write lands unchanged, whatever the tick did.
    assert_write_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[HALF-1:0] == $past(wdata[HALF-1:0])));
    // R8: a set flag survives any cycle without its clear.
    assert_sticky_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hi && !clr_hi) |=> ovf_hi);
    // R6: the pulse never lasts longer than the events that cause it.
    assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (ovf_lo || ovf_hi));
endmodule

// File: rtl/reload_timer.sv
// Module: reload_timer (top)
// A 16-bit auto-reload timer that can also run as two 8-bit timers.
// It has a selectable tick source, sticky overflow flags and an overflow
// pulse. Assumes one system clock domain; ext_osc may be asynchronous.
module reload_timer #(
    parameter int WIDTH       = 16,
    parameter int SYS_DIV     = 12,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel,
    input  logic             ext_osc,
    input  logic             split_en,
    input  logic             run_lo,
    input  logic             run_hi,
    input  logic [WIDTH-1:0] reload_val,
    input  logic             cnt_wr_lo,
    input  logic             cnt_wr_hi,
    input  logic [WIDTH-1:0] cnt_wdata,
    input  logic             flag_clr_lo,
    input  logic             flag_clr_hi,
    output logic [WIDTH-1:0] count,
    output logic             ovf_lo,
    output logic             ovf_hi,
    output logic             ovf_pulse
);
    logic tick;

    rtmr_tick_gen #(
        .SYS_DIV    (SYS_DIV),
        .EXT_DIV    (EXT_DIV),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_sel(clk_sel),
        .ext_osc(ext_osc),
        .tick   (tick)
    );

    rtmr_count_core #(
        .WIDTH(WIDTH)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .split_en  (split_en),
        .run_lo    (run_lo),
        .run_hi    (run_hi),
        .reload_val(reload_val),
        .wr_lo     (cnt_wr_lo),
        .wr_hi     (cnt_wr_hi),
        .wdata     (cnt_wdata),
        .clr_lo    (flag_clr_lo),
        .clr_hi    (flag_clr_hi),
        .count     (count),
        .ovf_lo    (ovf_lo),
        .ovf_hi    (ovf_hi),
        .ovf_pulse (ovf_pulse)
    );

    // R1: the cycle after reset shows a cleared timer.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && !ovf_lo && !ovf_hi && !ovf_pulse);
endmodule

// File: tb/reload_timer_tb_top.sv
// Bench: random and directed stimulus against a bench-side model.
module reload_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  clk_sel;
    logic        ext_osc, split_en, run_lo, run_hi;
    logic [15:0] reload_val, cnt_wdata;
    logic        cnt_wr_lo, cnt_wr_hi, flag_clr_lo, flag_clr_hi;
    logic [15:0] count;
    logic        ovf_lo, ovf_hi, ovf_pulse;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic [15:0] m_cnt;
    logic [1:0]  m_flg;
    logic        m_pls;
    bit          m_on = 1'b0;

    always #10 clk = ~clk;

    reload_timer dut_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_osc(ext_osc),
        .split_en(split_en), .run_lo(run_lo), .run_hi(run_hi),
        .reload_val(reload_val), .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi),
        .cnt_wdata(cnt_wdata), .flag_clr_lo(flag_clr_lo), .flag_clr_hi(flag_clr_hi),
        .count(count), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .ovf_pulse(ovf_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One 8-bit half of the split timer, from R4/R5/R7.
    function automatic logic [8:0] half_next(input logic [7:0] c, input logic run,
                                             input logic wr, input logic [7:0] wd,
                                             input logic [7:0] rl);
        if (wr) return {1'b0, wd};
        if (!run) return {1'b0, c};
        if (c == 8'hFF) return {1'b1, rl};
        return {1'b0, c + 8'd1};
    endfunction

    // Full next state {pulse, flags, count} with a tick every cycle (R2-R8 rules).
    function automatic logic [18:0] model_next(input logic [15:0] c, input logic [1:0] f);
        logic [15:0] n;
        logic [1:0]  e;
        logic [8:0]  lo, hi;
        e = 2'b00;
        if (split_en) begin
            lo = half_next(c[7:0], run_lo, cnt_wr_lo, cnt_wdata[7:0], reload_val[7:0]);
            hi = half_next(c[15:8], run_hi, cnt_wr_hi, cnt_wdata[15:8], reload_val[15:8]);
            n = {hi[7:0], lo[7:0]};
            e = {hi[8], lo[8]};
        end else if (cnt_wr_lo || cnt_wr_hi) begin
            n = {cnt_wr_hi ? cnt_wdata[15:8] : c[15:8], cnt_wr_lo ? cnt_wdata[7:0] : c[7:0]};
        end else if (run_lo) begin
            if (c == 16'hFFFF) begin n = reload_val; e = 2'b10; end
            else n = c + 16'd1;
        end else n = c;
        return {|e, (f & ~{flag_clr_hi, flag_clr_lo}) | e, n};
    endfunction

    task automatic idle_inputs();
        cnt_wr_lo = 0; cnt_wr_hi = 0; flag_clr_lo = 0; flag_clr_hi = 0;
    endtask

    // Advance one clock; the model follows when enabled; compare at the falling edge.
    task automatic step(input bit cmp);
        logic [18:0] r;
        @(posedge clk);
        if (m_on) begin
            r = model_next(m_cnt, m_flg);
            {m_pls, m_flg, m_cnt} = r;
        end
        @(negedge clk);
        if (cmp) begin
            check("R7 count vs model", count, m_cnt);
            check("R8 flags vs model", {ovf_hi, ovf_lo}, m_flg);
            check("R6 pulse vs model", ovf_pulse, m_pls);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_cnt = 0; m_flg = 0; m_pls = 0;
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            ext_osc = 1; repeat (4) @(negedge clk);
            ext_osc = 0; repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] base;
        int unsigned seed;
        rst_n = 0; clk_sel = 0; ext_osc = 0; split_en = 0; run_lo = 0; run_hi = 0;
        reload_val = 0; cnt_wdata = 0; idle_inputs();
        seed = 32'd7;
        void'($urandom(seed));
        do_reset();
        // R1 reset state
        check("R1 count", count, 16'h0);
        check("R1 flags", {ovf_hi, ovf_lo, ovf_pulse}, 3'b000);
        // R2 counting and holding
        run_lo = 1;
        repeat (5) step(0);
        check("R2 five ticks", count, 16'd5);
        run_lo = 0; run_hi = 1;
        repeat (3) step(0);
        check("R2 run_hi ignored", count, 16'd5);
        // R3 rollover with reload
        run_hi = 0; run_lo = 1; reload_val = 16'h1234;
        cnt_wdata = 16'hFFFE; cnt_wr_lo = 1; cnt_wr_hi = 1;
        step(0);
        idle_inputs();
        check("R7 write over count", count, 16'hFFFE);
        step(0);
        check("R3 at top", count, 16'hFFFF);
        check("R6 no pulse yet", ovf_pulse, 1'b0);
        step(0);
        check("R3 reloaded", count, 16'h1234);
        check("R3 flags hi only", {ovf_hi, ovf_lo}, 2'b10);
        check("R6 pulse", ovf_pulse, 1'b1);
        step(0);
        check("R6 pulse one cycle", ovf_pulse, 1'b0);
        check("R2 after reload", count, 16'h1235);
        // R8 clear coinciding with a new overflow keeps the flag
        cnt_wdata = 16'hFFFF; cnt_wr_lo = 1; cnt_wr_hi = 1;
        step(0);
        idle_inputs(); flag_clr_hi = 1;
        step(0);
        check("R8 set beats clear", ovf_hi, 1'b1);
        run_lo = 0;
        step(0);
        check("R8 cleared", ovf_hi, 1'b0);
        flag_clr_hi = 0;
        step(0);
        check("R8 stays clear", ovf_hi, 1'b0);
        // R7 low write while counting: no increment, high kept
        run_lo = 1;
        base = count;
        cnt_wdata = 16'hAB40; cnt_wr_lo = 1;
        step(0);
        idle_inputs();
        check("R7 low write priority", count, {base[15:8], 8'h40});
        // R4 split low half
        run_lo = 0; split_en = 1; reload_val = 16'h3CA5;
        cnt_wdata = 16'hFEFD; cnt_wr_lo = 1; cnt_wr_hi = 1;
        step(0);
        idle_inputs(); run_lo = 1;
        repeat (3) step(0);
        check("R4 low reload no carry", count, 16'hFEA5);
        check("R4 flags", {ovf_hi, ovf_lo, ovf_pulse}, 3'b011);
        // R5 split high half
        run_lo = 0; run_hi = 1; flag_clr_lo = 1;
        step(0);
        flag_clr_lo = 0;
        step(0);
        check("R5 high reload", count, 16'h3CA5);
        check("R5 flags", {ovf_hi, ovf_lo, ovf_pulse}, 3'b101);
        // random phase against the model, tick every cycle
        do_reset();
        m_on = 1;
        for (int i = 0; i < 600; i++) begin
            split_en = ($urandom % 4) == 0 ? ~split_en : split_en;
            run_lo = ($urandom % 8) != 0;
            run_hi = ($urandom % 8) != 0;
            reload_val = ($urandom % 2) ? (16'hFCFC | 16'($urandom % 4)) : 16'($urandom);
            cnt_wr_lo = ($urandom % 16) == 0;
            cnt_wr_hi = ($urandom % 16) == 0;
            cnt_wdata = ($urandom % 2) ? 16'hFFF8 : 16'($urandom);
            flag_clr_lo = ($urandom % 8) == 0;
            flag_clr_hi = ($urandom % 8) == 0;
            step(1);
        end
        m_on = 0;
        idle_inputs(); split_en = 0; run_hi = 0; run_lo = 1;
        // R9 off source
        clk_sel = 2'd3;
        step(0);
        base = count;
        repeat (10) step(0);
        check("R9 off holds", count, base);
        // R9 divide by 12
        clk_sel = 2'd1;
        step(0);
        base = count;
        repeat (48) step(0);
        check("R9 div12 rate", count - base, 16'd4);
        // R9 external divide by 8
        do_reset();
        clk_sel = 2'd2; run_lo = 1;
        ext_edges(16);
        repeat (10) step(0);
        check("R9 ext 16 edges", count, 16'd2);
        ext_edges(7);
        repeat (10) step(0);
        check("R9 ext 23 edges", count, 16'd2);
        ext_edges(1);
        repeat (10) step(0);
        check("R9 ext 24 edges", count, 16'd3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule